// File: doc/BRIEF.md
# Gated 16-bit Interval Timer

This block is a 16-bit up-counting timer driven through a small byte-wide register write port. In gated mode it counts prescaled clock ticks only while an external timer input sits at its programmed active level. Each time the count matches the reload value the counter restarts at 0001h, a reload event is raised and an optional timer output toggles. A fall of the gate from active to inactive is a second event source, and a two-bit selection field chooses which events drive the single-cycle interrupt pulse.

In compare mode the gate is ignored: the counter runs freely from its programmed start value and raises an event when it equals the compare (reload) value, then keeps counting upward. Software sets up count, reload, prescale, polarity and event selection while the timer is disabled, then sets the enable bit. All pins are plain control and status signals; there is no streaming data path, so no valid/ready handshake applies.

Top module: `gate_timer16`

## Requirements
- R1: After reset the count output is 0000h, the interrupt output is low and the timer output is low.
- R2: Writes use `wr_addr` 0 (count high byte), 1 (count low byte), 2 (reload high byte), 3 (reload low byte), 4 (control), 5 (event select, bits 1:0). Count writes take effect only while the enable bit is clear; while enabled they are ignored. While disabled the count holds its value.
- R3: Control bit 1 = 0 selects gated mode. Control bit 2 sets the gate polarity (1: input high is active, 0: input low is active). In gated mode the count advances only while the input, after a two-flop synchronizer, is active; otherwise it holds.
- R4: Control bits 5:3 hold a code p; the count advances once every 2^p clock cycles. The prescaler restarts from zero whenever the timer is disabled, so after the enabling write the first advance comes 2^p cycles later.
- R5: On an advance where the count equals the reload value, the count becomes 0001h and a reload event occurs; the programmed start value applies only to the first pass.
- R6: In gated mode with the timer enabled, a change of the synchronized gate from active to inactive is a deassertion event.
- R7: Event select 01 passes only deassertion events, 10 only reload events, 00 and 11 pass both.
- R8: With control bit 6 set, the timer output toggles on every reload event; with it clear the timer output is low.
- R9: Control bit 1 = 1 selects compare mode: the gate is ignored, the count advances on every prescaled tick, and on a match with the reload value an event occurs while counting continues upward; the pulse appears (compare − start + 1) × 2^p cycles after the enabling write.
- R10: The interrupt output is a single-cycle pulse, raised one cycle after the event, only while the timer is enabled; coincident events give one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| tmr_in | input | 1 | Asynchronous gate input |
| irq | output | 1 | Interrupt pulse |
| tmr_out | output | 1 | Toggling timer output |
| count_o | output | 16 | Current count value |

## Verification
Gated runs are driven from a table that mixes both gate polarities, prescale codes from 1 to 128, start values below and equal to the reload value, and run lengths spanning zero to many reload passes; the final count, the number of interrupt pulses and the timer output parity separate prescaler, wrap-to-0001h and first-pass start errors. Directed cases drop the gate with each event selection to tell deassertion events from reload events, write the count while enabled to show the write is refused, and run compare mode with the gate held inactive, where the exact cycle of the pulse and the count just after it distinguish compare from gated behaviour.

// File: rtl/gt_pkg.sv
package gt_pkg;
  localparam int CNT_W  = 16;
  localparam int PS_W   = 3;
  localparam int SYNC_N = 2;

  typedef enum logic [2:0] {
    A_CNT_HI = 3'd0,
    A_CNT_LO = 3'd1,
    A_RLD_HI = 3'd2,
    A_RLD_LO = 3'd3,
    A_CTRL   = 3'd4,
    A_EVSEL  = 3'd5
  } addr_e;

  typedef struct packed {
    logic            out_en;
    logic [PS_W-1:0] psel;
    logic            pol;
    logic            cmp_mode;
    logic            en;
  } ctrl_t;
endpackage

// File: rtl/gt_regs.sv
module gt_regs
  import gt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output ctrl_t            ctrl,
  output logic [1:0]       ev_sel,
  output logic [CNT_W-1:0] reload,
  output logic             cnt_wr_hi,
  output logic             cnt_wr_lo
);
  localparam int HALF = CNT_W / 2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= '0;
      ev_sel <= 2'b00;
      reload <= '0;
    end else if (wr_en) begin
      case (addr_e'(wr_addr))
        A_RLD_HI: reload[CNT_W-1:HALF] <= wr_data;
        A_RLD_LO: reload[HALF-1:0]     <= wr_data;
        A_CTRL:   ctrl                 <= ctrl_t'(wr_data[6:0]);
        A_EVSEL:  ev_sel               <= wr_data[1:0];
        default:  ;
      endcase
    end
  end

  // count writes are refused while the timer runs
  assign cnt_wr_hi = wr_en && (wr_addr == A_CNT_HI) && !ctrl.en;
  assign cnt_wr_lo = wr_en && (wr_addr == A_CNT_LO) && !ctrl.en;
endmodule

// File: rtl/gt_gate.sv
module gt_gate
  import gt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tmr_in,
  input  logic pol,
  output logic active,
  output logic fell
);
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;

  generate
    if (SYNC_N == 1) begin : g_one
      always_ff @(posedge clk)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= tmr_in;
    end else begin : g_chain
      always_ff @(posedge clk)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_N-2:0], tmr_in};
    end
  endgenerate

  assign active = pol ? sync_q[SYNC_N-1] : ~sync_q[SYNC_N-1];

  always_ff @(posedge clk)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= active;

  assign fell = prev_q && !active;

  // R6
  fell_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fell |=> !fell);
endmodule

// File: rtl/gt_prescale.sv
module gt_prescale
  import gt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [PS_W-1:0] psel,
  output logic            tick
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] mask;

  assign mask = ~({DIV_W{1'b1}} << psel);
  assign tick = en && ((pre_q & mask) == mask);

  always_ff @(posedge clk)
    if (!rst_n || !en) pre_q <= '0;
    else               pre_q <= pre_q + 1'b1;

  // R4
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && psel != '0 && en) |=> !tick);
endmodule

// File: rtl/gt_counter.sv
module gt_counter
  import gt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             cmp_mode,
  input  logic [CNT_W-1:0] reload,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic [7:0]       wr_data,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  localparam int HALF = CNT_W / 2;
  localparam logic [CNT_W-1:0] RESTART = CNT_W'(1);

  assign hit = adv && (count == reload);

  always_ff @(posedge clk) begin
    if (!rst_n)                count <= '0;
    else if (adv)              count <= (hit && !cmp_mode) ? RESTART : count + 1'b1;
    else if (wr_hi)            count[CNT_W-1:HALF] <= wr_data;
    else if (wr_lo)            count[HALF-1:0]     <= wr_data;
  end

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cmp_mode) |=> (count == RESTART));

  // R9
  cmp_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cmp_mode) |=> (count == $past(reload) + 1'b1));
endmodule

// File: rtl/gate_timer16.sv
module gate_timer16
  import gt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic        tmr_in,
  output logic        irq,
  output logic        tmr_out,
  output logic [15:0] count_o
);
  ctrl_t            ctrl;
  logic [1:0]       ev_sel;
  logic [CNT_W-1:0] reload;
  logic             cnt_wr_hi, cnt_wr_lo;
  logic             gate_act, gate_fell, tick, adv, hit;
  logic             ev_deassert, ev_reload, pass_d, pass_r;
  logic             irq_q, out_q;

  gt_regs u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .ctrl, .ev_sel, .reload, .cnt_wr_hi, .cnt_wr_lo
  );

  gt_gate u_gate (
    .clk, .rst_n, .tmr_in, .pol(ctrl.pol), .active(gate_act), .fell(gate_fell)
  );

  gt_prescale u_pre (
    .clk, .rst_n, .en(ctrl.en), .psel(ctrl.psel), .tick
  );

  assign adv = tick && (ctrl.cmp_mode || gate_act);

  gt_counter u_cnt (
    .clk, .rst_n, .adv, .cmp_mode(ctrl.cmp_mode), .reload,
    .wr_hi(cnt_wr_hi), .wr_lo(cnt_wr_lo), .wr_data,
    .count(count_o), .hit
  );

  assign ev_deassert = ctrl.en && !ctrl.cmp_mode && gate_fell;
  assign ev_reload   = hit;
  assign pass_d      = (ev_sel != 2'b10);
  assign pass_r      = (ev_sel != 2'b01);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      irq_q <= (ev_deassert && pass_d) || (ev_reload && pass_r);
      if (ev_reload) out_q <= ~out_q;
    end
  end

  assign irq     = irq_q;
  assign tmr_out = ctrl.out_en && out_q;

  // R10
  irq_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(ctrl.en));

  // R2
  hold_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.en && !cnt_wr_hi && !cnt_wr_lo) |=> $stable(count_o));

  // R3
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.en && !ctrl.cmp_mode && !gate_act) |=> $stable(count_o));

  // R8
  out_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q != $past(out_q)) |-> $past(ev_reload));
endmodule

// File: tb/gate_timer16_tb_top.sv
module gate_timer16_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        tmr_in = 1'b0;
  logic        irq, tmr_out;
  logic [15:0] count_o;

  int n_run = 0;
  int n_fail = 0;
  int irq_cnt = 0;
  int run_len = 0;
  int max_run = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gate_timer16 dut_i (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .tmr_in,
    .irq, .tmr_out, .count_o
  );

  always @(negedge clk) begin
    if (irq) begin
      irq_cnt++;
      run_len++;
      if (run_len > max_run) max_run = run_len;
    end else run_len = 0;
  end

  // pol, psel, start, reload, enabled cycles
  localparam int NV = 5;
  localparam logic [51:0] VEC [NV] = '{
    {1'b1, 3'd0, 16'h0000, 16'h0005, 16'd30},
    {1'b0, 3'd1, 16'h0003, 16'h0004, 16'd40},
    {1'b1, 3'd3, 16'h00FE, 16'h0100, 16'd100},
    {1'b0, 3'd7, 16'h0000, 16'h0001, 16'd600},
    {1'b1, 3'd2, 16'h1234, 16'h1234, 16'd23}
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input logic [7:0] ctl, input logic [1:0] sel,
                       input logic [15:0] st, input logic [15:0] rl);
    wr(3'd4, ctl);
    wr(3'd5, {6'd0, sel});
    wr(3'd0, st[15:8]);
    wr(3'd1, st[7:0]);
    wr(3'd2, rl[15:8]);
    wr(3'd3, rl[7:0]);
  endtask

  initial begin
    #1_600_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 count", count_o, 0);
    check("R1 irq", irq, 0);
    check("R1 tmr_out", tmr_out, 0);
    rst_n = 1'b1;

    // table of gated runs: R3 R4 R5 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic       pol;
      logic [2:0] ps;
      logic [15:0] st, rl, n;
      int ticks, c, r, out0;
      logic [7:0] ctl;
      {pol, ps, st, rl, n} = VEC[i];
      ctl = {1'b0, 1'b1, ps, pol, 1'b0, 1'b0};
      tmr_in = pol;
      setup(ctl, 2'b00, st, rl);
      repeat (4) @(posedge clk);
      @(negedge clk);
      out0 = tmr_out;
      irq_cnt = 0;
      wr(3'd4, ctl | 8'h01);
      repeat (int'(n)) @(posedge clk);
      wr(3'd4, ctl);
      repeat (3) @(posedge clk);
      @(negedge clk);
      ticks = (int'(n) + 1) / (1 << ps);
      c = int'(st); r = 0;
      for (int t = 0; t < ticks; t++) begin
        if (c == int'(rl)) begin c = 1; r++; end
        else c++;
      end
      check("R4/R5 count", count_o, c);
      check("R5 irq count", irq_cnt, r);
      check("R8 tmr_out", tmr_out, out0 ^ (r & 1));
    end

    // R2: count write while disabled takes effect, refused when enabled
    tmr_in = 1'b0;
    setup(8'h04, 2'b00, 16'h0A0B, 16'hFFFF);
    check("R2 write disabled", count_o, 16'h0A0B);
    wr(3'd4, 8'h05);
    wr(3'd1, 8'h77);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R2 write refused", count_o, 16'h0A0B);
    check("R3 gate inactive hold", count_o, 16'h0A0B);
    check("R8 out disabled", tmr_out, 0);

    // R6/R7 deassertion with each selection
    for (int s = 0; s < 3; s++) begin
      logic [1:0] sel;
      int hold;
      sel = (s == 0) ? 2'b01 : (s == 1) ? 2'b10 : 2'b00;
      wr(3'd4, 8'h04);
      tmr_in = 1'b1;
      setup(8'h04, sel, 16'h0000, 16'hFFFF);
      repeat (4) @(posedge clk);
      wr(3'd4, 8'h05);
      repeat (10) @(posedge clk);
      @(negedge clk);
      irq_cnt = 0; max_run = 0;
      tmr_in = 1'b0;
      repeat (8) @(posedge clk);
      @(negedge clk);
      check("R6/R7 deassert irq", irq_cnt, (sel == 2'b10) ? 0 : 1);
      if (sel != 2'b10) check("R10 pulse width", max_run, 1);
      hold = count_o;
      repeat (5) @(posedge clk);
      @(negedge clk);
      check("R3 hold after deassert", count_o, hold);
    end

    // R9 compare mode, gate inactive, prescale 4
    wr(3'd4, 8'h00);
    tmr_in = 1'b0;
    setup(8'h16, 2'b00, 16'h0010, 16'h0020);
    wr(3'd4, 8'h17);
    begin
      int first = 0;
      int cnt_at = 0;
      for (int k = 1; k <= 200; k++) begin
        @(posedge clk);
        @(negedge clk);
        if (irq && first == 0) begin first = k; cnt_at = count_o; end
      end
      check("R9 match cycle", first, 68);
      check("R9 count continues", cnt_at, 16'h0021);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule